// File: doc/BRIEF.md
# Protection-Key Access Permission Checker

This block decides whether a memory access may proceed based on a small per-thread rights register and a protection key. The key is a 4-bit field that the surrounding logic lifts out of the page table entry, so there are 16 keys. For every key the rights register holds a pair of bits: one that blocks all data access and one that blocks data writes. Software changes protection by rewriting this register, and no page entry has to change.

Each request carries the key, an access kind (data load, data store or instruction fetch) and a flag that says whether the core runs in 64-bit mode. The block returns a registered allow/fault verdict and a cause code one cycle later, qualified by a valid strobe. Instruction fetches and any access outside 64-bit mode are always allowed. A simple write strobe and a read-back bus take the place of the dedicated read and write instructions.

Top module: `pkey_guard`

## Requirements
- R1: After synchronous reset the rights register reads all zeros and `rsp_valid` is low; with all zeros every access for every key is allowed.
- R2: When `rights_we` is high at a clock edge, `rights_rdata` shows `rights_wdata` from the following cycle on; otherwise the register holds its value.
- R3: For key k the access-block bit is register bit 2k and the write-block bit is register bit 2k+1; bits of other keys do not affect key k.
- R4: In 64-bit mode, a data load (kind 2'b00) or data store (kind 2'b01) to a key whose access-block bit is set faults with cause 2'b01.
- R5: In 64-bit mode, with only the write-block bit set for the key, a data store faults with cause 2'b10 and a data load is allowed with cause 2'b00.
- R6: Kinds 2'b10 and 2'b11 are instruction fetches and are always allowed with cause 2'b00, whatever the register holds.
- R7: When `req_mode64` is low, every access is allowed with cause 2'b00.
- R8: `rsp_valid` is high exactly in the cycle after a cycle with `req_valid` high, and the verdict belongs to that request.
- R9: A request issued in the same cycle as a register write is judged against the register value from before the write.
- R10: Whenever `rsp_valid` is high, `rsp_allow` is high exactly when `rsp_cause` is 2'b00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rights_we | input | 1 | Write strobe for the rights register |
| rights_wdata | input | 32 | New rights register value |
| rights_rdata | output | 32 | Current rights register value |
| req_valid | input | 1 | Request present this cycle |
| req_key | input | 4 | Protection key from the page entry |
| req_kind | input | 2 | 00 load, 01 store, 10/11 fetch |
| req_mode64 | input | 1 | High when the core is in 64-bit mode |
| rsp_valid | output | 1 | Verdict valid |
| rsp_allow | output | 1 | 1 allow, 0 fault |
| rsp_cause | output | 2 | 00 none, 01 access blocked, 10 write blocked |

## Verification
The bench goes after the bit layout at both ends of the register (key 0 and key 15) and beside a set key, where a design with an off-by-one index would fault the wrong key or let the right one through. It pairs a load and a store under a write-block bit, which catches a design that faults loads or ranks the two causes wrongly. It issues a request in the same cycle as a register write, where a design bypassing the new value would fault too early, and it sends fetches and non-64-bit accesses under an all-ones register, where a design that forgets either exemption would fault.

// File: rtl/pkey_guard_pkg.sv
package pkey_guard_pkg;
  localparam int KEY_BITS = 4;
  localparam int NUM_KEYS = 1 << KEY_BITS;
  localparam int RIGHTS_W = 2 * NUM_KEYS;

  typedef enum logic [1:0] {
    KIND_LOAD      = 2'b00,
    KIND_STORE     = 2'b01,
    KIND_FETCH     = 2'b10,
    KIND_FETCH_ALT = 2'b11
  } acc_kind_e;

  typedef enum logic [1:0] {
    CAUSE_NONE      = 2'b00,
    CAUSE_NO_ACCESS = 2'b01,
    CAUSE_NO_WRITE  = 2'b10,
    CAUSE_RSVD      = 2'b11
  } cause_e;
endpackage

// File: rtl/pkey_rights_reg.sv
module pkey_rights_reg #(
  parameter int WIDTH = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             we,
  input  logic [WIDTH-1:0] wdata,
  output logic [WIDTH-1:0] rights
);
  logic [WIDTH-1:0] rights_q;

  always_ff @(posedge clk) begin
    if (rst) rights_q <= '0;
    else if (we) rights_q <= wdata;
  end

  assign rights = rights_q;

  // R2: a write shows up on the next cycle
  p_write_lands_r2: assert property (@(posedge clk) disable iff (rst)
    we |=> (rights == $past(wdata)));
  // R2: without a write the value holds
  p_hold_r2: assert property (@(posedge clk) disable iff (rst)
    !we |=> $stable(rights));
endmodule

// File: rtl/pkey_rule.sv
module pkey_rule
  import pkey_guard_pkg::*;
#(
  parameter int KBITS = 4,
  localparam int NKEYS = 1 << KBITS,
  localparam int RW = 2 * NKEYS
) (
  input  logic [RW-1:0]    rights,
  input  logic [KBITS-1:0] key,
  input  logic [1:0]       kind,
  input  logic             mode64,
  output logic             allow,
  output logic [1:0]       cause
);
  logic [NKEYS-1:0] block_all;
  logic [NKEYS-1:0] block_wr;

  for (genvar k = 0; k < NKEYS; k++) begin : g_split
    assign block_all[k] = rights[2*k];
    assign block_wr[k]  = rights[2*k+1];
  end

  logic is_data;
  logic is_store;
  assign is_data  = (kind == KIND_LOAD) || (kind == KIND_STORE);
  assign is_store = (kind == KIND_STORE);

  always_comb begin
    allow = 1'b1;
    cause = CAUSE_NONE;
    if (mode64 && is_data) begin
      if (block_all[key]) begin
        allow = 1'b0;
        cause = CAUSE_NO_ACCESS;
      end else if (block_wr[key] && is_store) begin
        allow = 1'b0;
        cause = CAUSE_NO_WRITE;
      end
    end
  end
endmodule

// File: rtl/pkey_verdict_reg.sv
module pkey_verdict_reg (
  input  logic       clk,
  input  logic       rst,
  input  logic       in_valid,
  input  logic       in_allow,
  input  logic [1:0] in_cause,
  output logic       out_valid,
  output logic       out_allow,
  output logic [1:0] out_cause
);
  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_allow <= 1'b1;
      out_cause <= 2'b00;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        out_allow <= in_allow;
        out_cause <= in_cause;
      end
    end
  end

  // R8: one verdict per request, one cycle later
  p_valid_follows_r8: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);
  p_no_spurious_r8: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !out_valid);
endmodule

// File: rtl/pkey_guard.sv
module pkey_guard
  import pkey_guard_pkg::*;
#(
  parameter int KBITS = KEY_BITS,
  localparam int NKEYS = 1 << KBITS,
  localparam int RW = 2 * NKEYS
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             rights_we,
  input  logic [RW-1:0]    rights_wdata,
  output logic [RW-1:0]    rights_rdata,
  input  logic             req_valid,
  input  logic [KBITS-1:0] req_key,
  input  logic [1:0]       req_kind,
  input  logic             req_mode64,
  output logic             rsp_valid,
  output logic             rsp_allow,
  output logic [1:0]       rsp_cause
);
  logic       dec_allow;
  logic [1:0] dec_cause;

  pkey_rights_reg #(.WIDTH(RW)) u_rights (
    .clk(clk), .rst(rst), .we(rights_we), .wdata(rights_wdata),
    .rights(rights_rdata)
  );

  // The rule sees the register output, so a same-cycle write is not yet visible (R9)
  pkey_rule #(.KBITS(KBITS)) u_rule (
    .rights(rights_rdata), .key(req_key), .kind(req_kind),
    .mode64(req_mode64), .allow(dec_allow), .cause(dec_cause)
  );

  pkey_verdict_reg u_out (
    .clk(clk), .rst(rst), .in_valid(req_valid), .in_allow(dec_allow),
    .in_cause(dec_cause), .out_valid(rsp_valid), .out_allow(rsp_allow),
    .out_cause(rsp_cause)
  );

  // R6: fetches never fault
  p_fetch_free_r6: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_kind[1]) |=> (rsp_allow && rsp_cause == 2'b00));
  // R7: outside 64-bit mode nothing faults
  p_legacy_free_r7: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !req_mode64) |=> rsp_allow);
  // R4: access-block bit stops loads and stores
  p_block_all_r4: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_mode64 && !req_kind[1] && rights_rdata[2*req_key])
      |=> (!rsp_allow && rsp_cause == 2'b01));
  // R5: write-block alone never stops a load
  p_load_passes_r5: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_kind == 2'b00 && !rights_rdata[2*req_key]) |=> rsp_allow);
  // R10: allow and cause agree
  p_cause_agrees_r10: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> (rsp_allow == (rsp_cause == 2'b00)));
endmodule

// File: tb/pkey_guard_test.sv
module pkey_guard_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        rights_we = 1'b0;
  logic [31:0] rights_wdata = '0;
  logic [31:0] rights_rdata;
  logic        req_valid = 1'b0;
  logic [3:0]  req_key = '0;
  logic [1:0]  req_kind = '0;
  logic        req_mode64 = 1'b0;
  logic        rsp_valid;
  logic        rsp_allow;
  logic [1:0]  rsp_cause;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  pkey_guard uut (
    .clk(clk), .rst(rst), .rights_we(rights_we), .rights_wdata(rights_wdata),
    .rights_rdata(rights_rdata), .req_valid(req_valid), .req_key(req_key),
    .req_kind(req_kind), .req_mode64(req_mode64), .rsp_valid(rsp_valid),
    .rsp_allow(rsp_allow), .rsp_cause(rsp_cause)
  );

  // fields: rights[41:10] key[9:6] kind[5:4] mode64[3] allow[2] cause[1:0]
  localparam int NV = 14;
  localparam logic [41:0] VEC [NV] = '{
    {32'h0000_0000, 4'd5,  2'b00, 1'b1, 1'b1, 2'b00},  // R1 zero rights allow
    {32'h0000_0040, 4'd3,  2'b00, 1'b1, 1'b0, 2'b01},  // R4 load blocked
    {32'h0000_0040, 4'd3,  2'b01, 1'b1, 1'b0, 2'b01},  // R4 store blocked
    {32'h0000_0080, 4'd3,  2'b01, 1'b1, 1'b0, 2'b10},  // R5 store write-blocked
    {32'h0000_0080, 4'd3,  2'b00, 1'b1, 1'b1, 2'b00},  // R5 load passes
    {32'h0000_00C0, 4'd3,  2'b01, 1'b1, 1'b0, 2'b01},  // R4 access block wins
    {32'h0000_0040, 4'd3,  2'b10, 1'b1, 1'b1, 2'b00},  // R6 fetch
    {32'hFFFF_FFFF, 4'd15, 2'b11, 1'b1, 1'b1, 2'b00},  // R6 alt fetch
    {32'hFFFF_FFFF, 4'd0,  2'b01, 1'b0, 1'b1, 2'b00},  // R7 not 64-bit
    {32'h0000_0040, 4'd2,  2'b01, 1'b1, 1'b1, 2'b00},  // R3 neighbour key
    {32'h8000_0000, 4'd15, 2'b01, 1'b1, 1'b0, 2'b10},  // R3 top write bit
    {32'h4000_0000, 4'd15, 2'b00, 1'b1, 1'b0, 2'b01},  // R3 top access bit
    {32'h0000_0002, 4'd1,  2'b00, 1'b1, 1'b1, 2'b00},  // R3 key0 bit not key1
    {32'h0000_0002, 4'd0,  2'b01, 1'b1, 1'b0, 2'b10}   // R3 key0 write bit
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic write_rights(input logic [31:0] v);
    @(negedge clk);
    rights_we = 1'b1; rights_wdata = v;
    @(negedge clk);
    rights_we = 1'b0;
  endtask

  // drives at negedge, verdict registered at next posedge, sampled next negedge
  task automatic issue(input logic [3:0] k, input logic [1:0] t, input logic m);
    req_valid = 1'b1; req_key = k; req_kind = t; req_mode64 = m;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      errors++;
      $display("FAIL watchdog: actual %0d cycles expected fewer", cycles);
      finish_run();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    check("R1 rights after reset", rights_rdata, 32'h0);
    check("R1 rsp_valid after reset", {31'b0, rsp_valid}, 32'h0);

    for (int i = 0; i < NV; i++) begin
      write_rights(VEC[i][41:10]);
      check("R2 readback", rights_rdata, VEC[i][41:10]);
      issue(VEC[i][9:6], VEC[i][5:4], VEC[i][3]);
      check("R8 rsp_valid", {31'b0, rsp_valid}, 32'h1);
      check($sformatf("R3-table vec %0d allow", i), {31'b0, rsp_allow}, {31'b0, VEC[i][2]});
      check($sformatf("R3-table vec %0d cause", i), {30'b0, rsp_cause}, {30'b0, VEC[i][1:0]});
      check("R10 allow matches cause", {31'b0, rsp_allow}, {31'b0, rsp_cause == 2'b00});
    end

    // R8: no request, no verdict
    @(negedge clk);
    check("R8 idle rsp_valid", {31'b0, rsp_valid}, 32'h0);

    // R9: same-cycle write and request use old value
    write_rights(32'h0);
    rights_we = 1'b1; rights_wdata = 32'hFFFF_FFFF;
    issue(4'd0, 2'b00, 1'b1);
    rights_we = 1'b0;
    check("R9 old value allows", {31'b0, rsp_allow}, 32'h1);
    check("R2 new value visible", rights_rdata, 32'hFFFF_FFFF);
    issue(4'd0, 2'b00, 1'b1);
    check("R9 new value faults", {30'b0, rsp_cause}, 32'h1);

    // R1: reset mid-run clears register
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    check("R1 rights cleared", rights_rdata, 32'h0);
    check("R1 rsp_valid cleared", {31'b0, rsp_valid}, 32'h0);
    issue(4'd9, 2'b01, 1'b1);
    check("R1 store allowed after reset", {31'b0, rsp_allow}, 32'h1);

    finish_run();
  end
endmodule